// File: doc/BRIEF.md
# Synchronous Multi-Converter Capture Controller

This block sits on the host side of a group of delta-sigma converters. The converters share one system clock and one serial clock. Each converter has its own combined ready/data line, which idles high and goes low when a conversion result is waiting. A capture is started by a one-cycle `start` pulse. The controller holds the shared serial clock high long enough for every converter to fall asleep. It then drives the clock low, which wakes all converters on the same edge so that their conversions begin together.

After the wake edge the controller waits with the serial clock low. It starts reading as soon as every ready line is low. It also starts reading if a skew window, counted in system-clock cycles, runs out after the first ready line fell. Reading means 24 serial-clock pulses. On each rising edge every converter moves to its next bit, most significant bit first, and all lanes are read in parallel. When the last bit is in, one word per channel is presented together with a one-cycle valid strobe. Any channel whose line was still high when the skew window closed is marked in a per-channel late flag, and its word is captured anyway.

The ready/data lines pass through a synchronizer before they are used. The serial-clock half period is a parameter and must be long enough to cover that synchronizer delay.

Top module: `acq_sync_capture`

## Requirements
- R1: While reset is held, `sclk`, `busy`, `cap_valid`, `late_flags` and `cap_words` are all zero.
- R2: A `start` pulse while idle raises `sclk` on the next clock edge. `sclk` then stays high for exactly `SLEEP_CYC` cycles before it falls, and that fall is the shared wake edge.
- R3: After the wake edge, `sclk` stays low until the synchronized view of every ready line is low. No serial-clock rising edge happens while a ready channel is still missing, unless the skew window has expired.
- R4: If at least one line has gone low but not all of them, reading begins no sooner than `SKEW_CYC` cycles after the first low line is seen. Each channel whose line is still high at that moment gets its `late_flags` bit set (bit n belongs to channel n). Channels that were ready get a zero bit.
- R5: A capture makes exactly `DW` rising edges on `sclk` after the wake edge. Each pulse is high for `HALF_CYC` cycles and low for `HALF_CYC` cycles.
- R6: The first bit read after the first rising edge is the most significant bit of each channel's word. Channel n occupies `cap_words[n*DW +: DW]`. A late channel whose line stays high reads as all ones.
- R7: `cap_valid` is high for exactly one cycle per capture. `cap_words` and `late_flags` change only in that cycle and hold their values until the next capture's valid cycle.
- R8: A `start` pulse while `busy` is high is ignored: it neither restarts the sleep phase nor produces an extra valid strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, shared with the converters |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to run a synchronized capture |
| rdy_dout | input | NCH | Ready/data line of each converter, idle high |
| sclk | output | 1 | Shared serial clock to all converters |
| busy | output | 1 | A capture sequence is in progress |
| cap_valid | output | 1 | One-cycle strobe: new words and flags are available |
| cap_words | output | NCH*DW | Captured word per channel, channel 0 in the low bits |
| late_flags | output | NCH | Per channel: line was not ready when the skew window closed |

## Verification
The hardest case to reach from the ports is the split outcome of the skew window. Some converters must answer within the window while others stay silent. The window must close partway through the wait, and the read must still run to completion.

The bench reaches this case with a behavioural model for each converter. Each model has its own wake-to-ready delay, and a negative delay means the model never answers. Mixing short delays with silent channels makes the controller take the timeout path. A case where every channel answers, with the slowest one just inside the window, checks that the controller waits for the last line rather than timing out. A start pulse issued mid-read covers the case where the request must be ignored.

// File: rtl/acq_pkg.sv
package acq_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SLEEP = 2'd1,
      ST_WAIT  = 2'd2,
      ST_SHIFT = 2'd3
   } acq_state_e;

   function automatic int unsigned bits_for(input int unsigned v);
      return (v < 2) ? 1 : $clog2(v);
   endfunction

endpackage

// File: rtl/acq_in_sync.sv
module acq_in_sync #(
   parameter int unsigned W       = 4,
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES == 0) begin : g_pass
         assign q = d;
      end else begin : g_chain
         logic [W-1:0] stg_q [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stg_q[i] <= {W{RST_VAL}};
            end else begin
               stg_q[0] <= d;
               for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
            end
         end
         assign q = stg_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/acq_sclk_gen.sv
module acq_sclk_gen #(
   parameter int unsigned HALF = 4,
   parameter int unsigned BITS = 24
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic hi,
   output logic sample,
   output logic last,
   output logic active
);
   import acq_pkg::*;

   localparam int unsigned PW = bits_for(2 * HALF);
   localparam int unsigned BW = bits_for(BITS);
   localparam logic [PW-1:0] PH_FALL = PW'(HALF - 1);
   localparam logic [PW-1:0] PH_END  = PW'(2 * HALF - 1);
   localparam logic [BW-1:0] BIT_END = BW'(BITS - 1);

   logic [PW-1:0] ph_q;
   logic [BW-1:0] bit_q;
   logic          act_q;
   logic          hi_q;

   assign sample = act_q && (ph_q == PH_END);
   assign last   = sample && (bit_q == BIT_END);
   assign hi     = hi_q;
   assign active = act_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q  <= '0;
         bit_q <= '0;
         act_q <= 1'b0;
         hi_q  <= 1'b0;
      end else if (!act_q) begin
         if (run) begin
            act_q <= 1'b1;
            ph_q  <= '0;
            bit_q <= '0;
            hi_q  <= 1'b1;
         end
      end else if (ph_q == PH_END) begin
         if (bit_q == BIT_END) begin
            act_q <= 1'b0;
            hi_q  <= 1'b0;
         end else begin
            bit_q <= bit_q + 1'b1;
            ph_q  <= '0;
            hi_q  <= 1'b1;
         end
      end else begin
         ph_q <= ph_q + 1'b1;
         if (ph_q == PH_FALL) hi_q <= 1'b0;
      end
   end

endmodule

// File: rtl/acq_lane.sv
module acq_lane #(
   parameter int unsigned DW = 24
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          shift,
   input  logic          commit,
   input  logic          din,
   input  logic          late_ld,
   input  logic          late_in,
   output logic [DW-1:0] word,
   output logic          late
);

   logic [DW-1:0] sh_q;
   logic [DW-1:0] sh_nx;
   logic          pend_q;

   assign sh_nx = {sh_q[DW-2:0], din};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '0;
         pend_q <= 1'b0;
         word   <= '0;
         late   <= 1'b0;
      end else begin
         if (shift)   sh_q   <= sh_nx;
         if (late_ld) pend_q <= late_in;
         if (commit) begin
            word <= sh_nx;
            late <= pend_q;
         end
      end
   end

endmodule

// File: rtl/acq_sync_capture.sv
module acq_sync_capture #(
   parameter int unsigned NCH         = 4,
   parameter int unsigned DW          = 24,
   parameter int unsigned HALF_CYC    = 4,
   parameter int unsigned SLEEP_CYC   = 163840,
   parameter int unsigned SKEW_CYC    = 1229,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [NCH-1:0]    rdy_dout,
   output logic              sclk,
   output logic              busy,
   output logic              cap_valid,
   output logic [NCH*DW-1:0] cap_words,
   output logic [NCH-1:0]    late_flags
);
   import acq_pkg::*;

   localparam int unsigned TMAX = (SLEEP_CYC > SKEW_CYC) ? SLEEP_CYC : SKEW_CYC;
   localparam int unsigned TW   = bits_for(TMAX + 1);
   localparam logic [TW-1:0] T_SLEEP_END = TW'(SLEEP_CYC - 1);
   localparam logic [TW-1:0] T_SKEW_END  = TW'(SKEW_CYC - 1);

   generate
      if (NCH < 1) begin : g_bad_nch
         $error("acq_sync_capture: NCH must be at least 1");
      end
      if (DW < 2) begin : g_bad_dw
         $error("acq_sync_capture: DW must be at least 2");
      end
      if (HALF_CYC < 1 || 2 * HALF_CYC <= SYNC_STAGES) begin : g_bad_half
         $error("acq_sync_capture: serial half period too short for synchronizer");
      end
      if (SLEEP_CYC <= SYNC_STAGES + 1) begin : g_bad_sleep
         $error("acq_sync_capture: sleep hold must exceed synchronizer depth");
      end
      if (SKEW_CYC < 1) begin : g_bad_skew
         $error("acq_sync_capture: skew window must be at least one cycle");
      end
   endgenerate

   acq_state_e     state_q;
   logic [TW-1:0]  tmr_q;
   logic           seen_q;
   logic           sleep_hi_q;
   logic           valid_q;
   logic [NCH-1:0] rdy_s;
   logic           all_rdy;
   logic           any_rdy;
   logic           skew_up;
   logic           go;
   logic           gen_hi;
   logic           gen_sample;
   logic           gen_last;
   logic           gen_active;

   acq_in_sync #(
      .W       (NCH),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (1'b1)
   ) in_sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (rdy_dout),
      .q     (rdy_s)
   );

   assign all_rdy = ~|rdy_s;
   assign any_rdy = ~&rdy_s;
   assign skew_up = seen_q && (tmr_q == T_SKEW_END);
   assign go      = (state_q == ST_WAIT) && (all_rdy || skew_up);

   acq_sclk_gen #(
      .HALF (HALF_CYC),
      .BITS (DW)
   ) sclk_gen_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (go),
      .hi     (gen_hi),
      .sample (gen_sample),
      .last   (gen_last),
      .active (gen_active)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         tmr_q      <= '0;
         seen_q     <= 1'b0;
         sleep_hi_q <= 1'b0;
         valid_q    <= 1'b0;
      end else begin
         valid_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start) begin
                  state_q    <= ST_SLEEP;
                  sleep_hi_q <= 1'b1;
                  tmr_q      <= '0;
               end
            end
            ST_SLEEP: begin
               if (tmr_q == T_SLEEP_END) begin
                  state_q    <= ST_WAIT;
                  sleep_hi_q <= 1'b0;
                  tmr_q      <= '0;
                  seen_q     <= 1'b0;
               end else begin
                  tmr_q <= tmr_q + 1'b1;
               end
            end
            ST_WAIT: begin
               if (go) begin
                  state_q <= ST_SHIFT;
               end else begin
                  seen_q <= seen_q | any_rdy;
                  if (seen_q) tmr_q <= tmr_q + 1'b1;
               end
            end
            ST_SHIFT: begin
               if (gen_last) begin
                  state_q <= ST_IDLE;
                  valid_q <= 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   generate
      for (genvar g = 0; g < NCH; g++) begin : g_lane
         acq_lane #(
            .DW (DW)
         ) lane_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .shift   (gen_sample),
            .commit  (gen_last),
            .din     (rdy_s[g]),
            .late_ld (go),
            .late_in (rdy_s[g]),
            .word    (cap_words[g*DW +: DW]),
            .late    (late_flags[g])
         );
      end
   endgenerate

   assign sclk      = sleep_hi_q | gen_hi;
   assign busy      = (state_q != ST_IDLE) || gen_active;
   assign cap_valid = valid_q;

endmodule

// File: rtl/acq_sync_capture_chk.sv
module acq_sync_capture_chk #(
   parameter int unsigned NCH       = 4,
   parameter int unsigned WW        = 96,
   parameter int unsigned HALF_CYC  = 4,
   parameter int unsigned SLEEP_CYC = 64
) (
   input logic                clk,
   input logic                rst_n,
   input logic                start,
   input logic                sclk,
   input logic                busy,
   input logic                cap_valid,
   input logic [WW-1:0]       cap_words,
   input logic [NCH-1:0]      late_flags,
   input acq_pkg::acq_state_e st
);
   import acq_pkg::*;

   localparam int unsigned RMAX = (SLEEP_CYC > HALF_CYC) ? SLEEP_CYC : HALF_CYC;
   localparam int unsigned RW   = bits_for(RMAX + 2) + 1;

   logic [RW-1:0] hi_run_q;
   logic [RW-1:0] lo_run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_run_q <= '0;
         lo_run_q <= '0;
      end else begin
         hi_run_q <= sclk ? ((hi_run_q == '1) ? hi_run_q : hi_run_q + 1'b1) : '0;
         lo_run_q <= sclk ? '0 : ((lo_run_q == '1) ? lo_run_q : lo_run_q + 1'b1);
      end
   end

   // R2
   sleep_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(sclk) && st == ST_WAIT) |-> (hi_run_q == RW'(SLEEP_CYC)));

   // R3
   wait_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_WAIT) |-> !sclk);

   // R5
   bit_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(sclk) && st == ST_SHIFT) |-> (hi_run_q == RW'(HALF_CYC)));

   // R5
   bit_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(sclk) && st == ST_SHIFT && $past(st) == ST_SHIFT) |-> (lo_run_q == RW'(HALF_CYC)));

   // R7
   valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cap_valid |=> !cap_valid);

   // R7
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_valid |-> ($stable(cap_words) && $stable(late_flags)));

   // R8
   busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_SHIFT && start) |=> (st != ST_SLEEP));

   // R7
   valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cap_valid |-> !busy);

endmodule

bind acq_sync_capture acq_sync_capture_chk #(
   .NCH       (NCH),
   .WW        (NCH * DW),
   .HALF_CYC  (HALF_CYC),
   .SLEEP_CYC (SLEEP_CYC)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .sclk       (sclk),
   .busy       (busy),
   .cap_valid  (cap_valid),
   .cap_words  (cap_words),
   .late_flags (late_flags),
   .st         (state_q)
);

// File: tb/acq_sync_capture_tb_top.sv
`timescale 1ns/1ps
module acq_sync_capture_tb_top;
   localparam int NCH   = 4;
   localparam int DW    = 24;
   localparam int HALF  = 2;
   localparam int SLEEP = 64;
   localparam int SKEW  = 40;
   localparam int SYNC  = 2;

   typedef struct packed {
      logic [NCH-1:0]    late;
      logic [NCH*DW-1:0] words;
   } exp_t;

   logic              clk   = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   wire  [NCH-1:0]    line;
   wire               sclk;
   wire               busy;
   wire               cap_valid;
   wire  [NCH*DW-1:0] cap_words;
   wire  [NCH-1:0]    late_flags;

   int          n_chk = 0;
   int          n_bad = 0;
   int          cyc   = 0;
   bit          done  = 1'b0;
   int          dly [NCH];
   logic [DW-1:0] dat [NCH];
   exp_t        exp_q [$];

   acq_sync_capture #(
      .NCH (NCH), .DW (DW), .HALF_CYC (HALF), .SLEEP_CYC (SLEEP),
      .SKEW_CYC (SKEW), .SYNC_STAGES (SYNC)
   ) dut_i (
      .clk (clk), .rst_n (rst_n), .start (start), .rdy_dout (line),
      .sclk (sclk), .busy (busy), .cap_valid (cap_valid),
      .cap_words (cap_words), .late_flags (late_flags)
   );

   always #4 clk = ~clk;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [NCH*DW-1:0] act, input logic [NCH*DW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // converter models: sleep on long high, ready after dly, then MSB-first bits
   for (genvar g = 0; g < NCH; g++) begin : g_dev
      logic ln = 1'b1;
      assign line[g] = ln;
      initial begin
         forever begin
            @(posedge sclk);
            ln <= 1'b1;
            @(negedge sclk);
            if (dly[g] < 0) begin
               @(posedge cap_valid);
            end else begin
               repeat (dly[g]) @(posedge clk);
               ln <= 1'b0;
               for (int i = DW - 1; i >= 0; i--) begin
                  @(posedge sclk);
                  ln <= dat[g][i];
               end
               @(posedge cap_valid);
            end
         end
      end
   end

   // scoreboard monitor
   initial begin : mon
      exp_t e;
      bit   pv;
      pv = 1'b0;
      forever begin
         @(negedge clk);
         if (cap_valid) begin
            check(!pv, "R7", "valid longer than one cycle", 96'(pv), 96'(0));
            if (exp_q.size() == 0) begin
               check(1'b0, "R8", "valid without request", 96'(1), 96'(0));
            end else begin
               e = exp_q.pop_front();
               for (int c = 0; c < NCH; c++)
                  check(cap_words[c*DW +: DW] == e.words[c*DW +: DW], "R6", "channel word",
                        96'(cap_words[c*DW +: DW]), 96'(e.words[c*DW +: DW]));
               check(late_flags == e.late, "R4", "late flags", 96'(late_flags), 96'(e.late));
            end
         end
         pv = cap_valid;
      end
   end

   task automatic run_cap(input bit poke_busy);
      exp_t e;
      int   t;
      int   cnt;
      int   first;
      int   rises;
      logic prev;
      logic [NCH-1:0] prev_line;
      for (int c = 0; c < NCH; c++) begin
         e.late[c]         = (dly[c] < 0);
         e.words[c*DW +: DW] = (dly[c] < 0) ? {DW{1'b1}} : dat[c];
      end
      exp_q.push_back(e);
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      t = 0;
      while (sclk) begin t++; @(negedge clk); end
      check(t == SLEEP, "R2", "sleep hold length", 96'(t), 96'(SLEEP));
      cnt = 0; first = -1; prev_line = line;
      while (!sclk) begin
         if (first < 0 && line != '1) first = cnt;
         prev_line = line;
         cnt++;
         @(negedge clk);
      end
      if (e.late == '0) begin
         check(prev_line == '0, "R3", "lines before first read edge", 96'(prev_line), 96'(0));
      end else begin
         check(first >= 0 && (cnt - first) >= SKEW && (cnt - first) <= SKEW + SYNC + 4,
               "R4", "skew wait length", 96'(cnt - first), 96'(SKEW));
      end
      if (poke_busy) begin
         start = 1'b1; @(negedge clk); start = 1'b0;
      end
      rises = 1; prev = sclk;
      while (busy) begin
         @(negedge clk);
         if (sclk && !prev) rises++;
         prev = sclk;
      end
      check(rises == DW, "R5", "read edge count", 96'(rises), 96'(DW));
      repeat (6) @(negedge clk);
      check(cap_words == e.words, "R7", "words held after valid", cap_words, e.words);
      check(busy == 1'b0, "R8", "idle after capture", 96'(busy), 96'(0));
   endtask

   initial begin
      for (int c = 0; c < NCH; c++) begin dly[c] = 1; dat[c] = '0; end
      repeat (3) @(negedge clk);
      // R1
      check(sclk == 1'b0 && busy == 1'b0 && cap_valid == 1'b0, "R1", "control outputs in reset",
            96'({sclk, busy, cap_valid}), 96'(0));
      check(late_flags == '0 && cap_words == '0, "R1", "data outputs in reset",
            cap_words, 96'(0));
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      dly = '{5, 9, 3, 12};
      dat = '{24'hA5F00F, 24'h123456, 24'h800000, 24'h7FFFFF};
      run_cap(1'b0);

      dly = '{4, -1, 7, 2};
      dat = '{24'h0F0F0F, 24'h000000, 24'hC3C3C3, 24'h5A5A5A};
      run_cap(1'b0);

      dly = '{-1, 6, -1, 3};
      dat = '{24'h000000, 24'h800001, 24'h000000, 24'hFEDCBA};
      run_cap(1'b1);

      dly = '{1, 1, 1, 1};
      dat = '{24'h000001, 24'hFFFFFE, 24'h000000, 24'hFFFFFF};
      run_cap(1'b0);

      dly = '{2, 30, 8, 15};
      dat = '{24'h13579B, 24'h2468AC, 24'hFFF000, 24'h000FFF};
      run_cap(1'b1);

      repeat (10) @(negedge clk);
      check(exp_q.size() == 0, "R6", "results left unmatched", 96'(exp_q.size()), 96'(0));
      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc > 100000 && !done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL R5 watchdog expired actual=%0d expected=%0d", cyc, 100000);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
         end
      end
   end

endmodule